// File: doc/BRIEF.md
# Data Access Address Translation Checker

This block takes one load or store request per cycle, together with the result of a translation-buffer lookup made for the same virtual address. It decides whether the access may proceed, and it forms the physical address when it can. When the access cannot proceed, it reports a fault class and a six-bit status vector that says why. The translation array itself sits outside the block: the requester presents the lookup outcome on the `tlb_*` inputs in the same cycle as the request.

The checks run in a fixed priority order:

1. natural alignment against the access size;
2. untranslated (physical) bypass;
3. the canonical-form test of the virtual address;
4. the kernel-only direct-mapped superpage window;
5. lookup miss classification;
6. per-mode read and write enables, plus the fault-on-read and fault-on-write page bits.

A final stage then applies two more checks to every address that survives. Addresses beyond the implemented physical range raise a machine check. Addresses carrying the uncached bit are marked uncached and have an alias field cleared.

Privileged code (program counter low bit set) runs with an effective mode. That mode is taken from the alternate-mode input when the request asks for it, and is kernel otherwise. All results are registered and appear one cycle after the request. Separate read and write hit, miss and violation strobes support event counting.

Top module: `dtc_xlate`

## Requirements
- R1: A request whose address has any bit below 2^req_size set returns fault code 1 (alignment), before every other check. Its status has only bit 0 (store) set, and only for stores. No hit, miss or violation strobe fires.
- R2: When req_priv_pc is 1, the mode used for the permission check is alt_mode if req_alt is 1, and kernel (0) otherwise. When req_priv_pc is 0, it is cur_mode. The enable bit consulted is the one indexed by that mode.
- R3: With req_phys set, the physical address equals the virtual address, still subject to R10 and R11. No strobe fires.
- R4: When address bits 63..47 are not all equal, the result is fault code 2 (page fault). Status is bit 0 for stores, bit 1 (bad address) and bit 2 (violation), and a violation strobe fires.
- R5: Bits 47..41 equal to 0x7E select the superpage. It is allowed only when cur_mode is 0, whatever the effective mode is. Otherwise the result is fault code 3 (violation) with status bit 0 for stores and bit 2, plus a violation strobe. On success the physical address is the low 44 address bits with bits 43..40 set when bit 40 is set and cleared otherwise, and a hit strobe fires.
- R6: A lookup miss gives status bit 3 plus bit 0 for stores, and a miss strobe. The fault code is 4 when req_pt_fetch is 1 and 5 otherwise.
- R7: A store whose write enable is clear gives fault code 2 with status bits 0 and 2, plus bit 5 if the fault-on-write bit is set. A permitted store with fault-on-write set gives fault code 2 with status bits 0 and 5 only. Both fire a write violation strobe.
- R8: A load whose read enable is clear gives fault code 3 with status bit 2, plus bit 4 if fault-on-read is set. A permitted load with fault-on-read set gives fault code 2 with status bit 4 only. Both fire a read violation strobe.
- R9: A lookup hit with permission granted forms the physical address as (tlb_ppn << 13) plus the 13-bit page offset, and fires a hit strobe.
- R10: A surviving address with any bit at 44 or above returns fault code 6 (machine check) with zero status. The hit strobe of its path still fires.
- R11: A surviving address with bit 43 set returns rsp_uncached = 1, with bits 42..35 of the physical address cleared.
- R12: Each result appears exactly one cycle after its request. At most one strobe fires per response, on the read or write side according to req_store. Every faulting response has zero physical address and uncached flag, and no output is active without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_size | input | 2 | log2 of access bytes |
| req_store | input | 1 | 1 = store, 0 = load |
| req_priv_pc | input | 1 | Program counter low bit (privileged code) |
| req_alt | input | 1 | Use alternate mode under privileged code |
| req_phys | input | 1 | Physical bypass |
| req_pt_fetch | input | 1 | Request is a page-table fetch |
| alt_mode | input | 2 | Alternate mode value |
| cur_mode | input | 2 | Current mode (0 = kernel) |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_ppn | input | 32 | Physical page number of the entry |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fault_rd | input | 1 | Fault-on-read page bit |
| tlb_fault_wr | input | 1 | Fault-on-write page bit |
| rsp_valid | output | 1 | Result present |
| rsp_paddr | output | 44 | Physical address (0 on fault) |
| rsp_fault | output | 3 | Fault code (0 = none) |
| rsp_status | output | 6 | Status flags |
| rsp_uncached | output | 1 | Access is uncached |
| rd_hit | output | 1 | Load hit strobe |
| rd_miss | output | 1 | Load miss strobe |
| rd_viol | output | 1 | Load violation strobe |
| wr_hit | output | 1 | Store hit strobe |
| wr_miss | output | 1 | Store miss strobe |
| wr_viol | output | 1 | Store violation strobe |

## Verification
The bench builds the block with its default parameters. These are a 64-bit virtual address with a 48-bit implemented range, 8 KiB pages, a 32-bit page number, a 44-bit physical range, uncached bit 43 and superpage extension bit 40.

With these values, a page number whose top bits pass bit 43 or 44 reaches both the uncached path and the machine-check path from an ordinary lookup hit. The superpage window sits inside the canonical upper half, so its sign-extension and uncached cases can both be reached.

Directed requests cover each priority step and the mode corners. A long mixed random phase is then compared every cycle against a behavioural model.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
   typedef enum logic [2:0] {
      FLT_NONE    = 3'd0,
      FLT_ALIGN   = 3'd1,
      FLT_PAGE    = 3'd2,
      FLT_ACV     = 3'd3,
      FLT_PT_MISS = 3'd4,
      FLT_MISS    = 3'd5,
      FLT_MCHK    = 3'd6
   } dtc_fault_e;

   localparam int ST_WR    = 0;
   localparam int ST_BADVA = 1;
   localparam int ST_ACV   = 2;
   localparam int ST_MISS  = 3;
   localparam int ST_FOR   = 4;
   localparam int ST_FOW   = 5;
   localparam int ST_W     = 6;

   typedef logic [ST_W-1:0] dtc_stat_t;
endpackage

// File: rtl/dtc_mode_sel.sv
module dtc_mode_sel #(
   parameter int MW = 2
) (
   input  logic          priv_pc,
   input  logic          alt_req,
   input  logic [MW-1:0] alt_mode,
   input  logic [MW-1:0] cur_mode,
   output logic [MW-1:0] eff_mode
);
   always_comb begin
      if (priv_pc) eff_mode = alt_req ? alt_mode : '0;
      else         eff_mode = cur_mode;
   end
endmodule

// File: rtl/dtc_perm_eval.sv
module dtc_perm_eval
   import dtc_pkg::*;
#(
   parameter int MW = 2,
   localparam int NM = 1 << MW
) (
   input  logic          is_store,
   input  logic [MW-1:0] mode,
   input  logic [NM-1:0] rd_en,
   input  logic [NM-1:0] wr_en,
   input  logic          fault_rd,
   input  logic          fault_wr,
   output logic          fault,
   output dtc_fault_e    code,
   output dtc_stat_t     stat
);
   logic allow;
   assign allow = is_store ? wr_en[mode] : rd_en[mode];

   always_comb begin
      fault = 1'b0;
      code  = FLT_NONE;
      stat  = '0;
      if (is_store) begin
         if (!allow) begin
            fault        = 1'b1;
            code         = FLT_PAGE;
            stat[ST_WR]  = 1'b1;
            stat[ST_ACV] = 1'b1;
            stat[ST_FOW] = fault_wr;
         end else if (fault_wr) begin
            fault        = 1'b1;
            code         = FLT_PAGE;
            stat[ST_WR]  = 1'b1;
            stat[ST_FOW] = 1'b1;
         end
      end else begin
         if (!allow) begin
            fault        = 1'b1;
            code         = FLT_ACV;
            stat[ST_ACV] = 1'b1;
            stat[ST_FOR] = fault_rd;
         end else if (fault_rd) begin
            fault        = 1'b1;
            code         = FLT_PAGE;
            stat[ST_FOR] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dtc_pa_final.sv
module dtc_pa_final #(
   parameter int VA_W       = 64,
   parameter int PA_IMPL    = 44,
   parameter int UNC_BIT    = 43,
   parameter int UNC_CLR_LO = 35
) (
   input  logic [VA_W-1:0]    pa_in,
   output logic [PA_IMPL-1:0] pa_out,
   output logic               mchk,
   output logic               uncached
);
   localparam logic [PA_IMPL-1:0] CLR_MASK =
      (PA_IMPL'(1) << UNC_BIT) - (PA_IMPL'(1) << UNC_CLR_LO);

   if (UNC_BIT >= PA_IMPL || UNC_CLR_LO >= UNC_BIT) begin : g_bad_unc
      $error("dtc_pa_final: uncached bit field out of range");
   end
   if (PA_IMPL >= VA_W) begin : g_bad_pa
      $error("dtc_pa_final: physical range must be narrower than the address");
   end

   assign mchk     = |pa_in[VA_W-1:PA_IMPL];
   assign uncached = !mchk && pa_in[UNC_BIT];
   assign pa_out   = uncached ? (pa_in[PA_IMPL-1:0] & ~CLR_MASK) : pa_in[PA_IMPL-1:0];
endmodule

// File: rtl/dtc_xlate.sv
module dtc_xlate
   import dtc_pkg::*;
#(
   parameter int          VA_W        = 64,
   parameter int          VA_IMPL     = 48,
   parameter int          PA_IMPL     = 44,
   parameter int          PAGE_SHIFT  = 13,
   parameter int          PPN_W       = 32,
   parameter int          MODE_W      = 2,
   parameter int          SIZE_W      = 2,
   parameter int          SP_TAG_W    = 7,
   parameter logic [6:0]  SP_TAG      = 7'h7E,
   parameter bit          SP_SIGN_EXT = 1'b1,
   parameter int          SP_EXT_BIT  = 40,
   parameter int          UNC_BIT     = 43,
   parameter int          UNC_CLR_LO  = 35
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [VA_W-1:0]          req_vaddr,
   input  logic [SIZE_W-1:0]        req_size,
   input  logic                     req_store,
   input  logic                     req_priv_pc,
   input  logic                     req_alt,
   input  logic                     req_phys,
   input  logic                     req_pt_fetch,
   input  logic [MODE_W-1:0]        alt_mode,
   input  logic [MODE_W-1:0]        cur_mode,
   input  logic                     tlb_hit,
   input  logic [PPN_W-1:0]         tlb_ppn,
   input  logic [(1<<MODE_W)-1:0]   tlb_rd_en,
   input  logic [(1<<MODE_W)-1:0]   tlb_wr_en,
   input  logic                     tlb_fault_rd,
   input  logic                     tlb_fault_wr,
   output logic                     rsp_valid,
   output logic [PA_IMPL-1:0]       rsp_paddr,
   output logic [2:0]               rsp_fault,
   output logic [ST_W-1:0]          rsp_status,
   output logic                     rsp_uncached,
   output logic                     rd_hit,
   output logic                     rd_miss,
   output logic                     rd_viol,
   output logic                     wr_hit,
   output logic                     wr_miss,
   output logic                     wr_viol
);
   localparam int NMODES    = 1 << MODE_W;
   localparam int ALIGN_W   = (1 << SIZE_W) - 1;
   localparam int SP_TAG_LO = VA_IMPL - SP_TAG_W;
   localparam logic [VA_W-1:0] IMPL_MASK = (VA_W'(1) << PA_IMPL) - VA_W'(1);
   localparam logic [VA_W-1:0] EXT_MASK  = IMPL_MASK & ~((VA_W'(1) << SP_EXT_BIT) - VA_W'(1));

   if (PPN_W + PAGE_SHIFT > VA_W) begin : g_bad_ppn
      $error("dtc_xlate: page number and offset exceed the address width");
   end
   if (SP_TAG_W > 7 || SP_TAG_LO <= SP_EXT_BIT) begin : g_bad_sp
      $error("dtc_xlate: superpage tag placement invalid");
   end
   if (VA_IMPL > VA_W || ALIGN_W >= PAGE_SHIFT) begin : g_bad_va
      $error("dtc_xlate: virtual range or size field invalid");
   end

   // ---- front checks ----
   logic [ALIGN_W-1:0] amask;
   logic               misalign, canon, in_sp;
   assign amask    = ALIGN_W'((32'd1 << req_size) - 32'd1);
   assign misalign = |(req_vaddr[ALIGN_W-1:0] & amask);
   assign in_sp    = (req_vaddr[VA_IMPL-1:SP_TAG_LO] == SP_TAG[SP_TAG_W-1:0]);

   if (VA_IMPL == VA_W) begin : g_canon_all
      assign canon = 1'b1;
   end else begin : g_canon_chk
      logic [VA_W-VA_IMPL:0] hi;
      assign hi    = req_vaddr[VA_W-1:VA_IMPL-1];
      assign canon = (&hi) || !(|hi);
   end

   // ---- superpage address ----
   logic [VA_W-1:0] sp_masked, sp_pa;
   assign sp_masked = req_vaddr & IMPL_MASK;
   if (SP_SIGN_EXT) begin : g_sp_ext
      assign sp_pa = sp_masked[SP_EXT_BIT] ? (sp_masked | EXT_MASK) : (sp_masked & ~EXT_MASK);
   end else begin : g_sp_plain
      assign sp_pa = sp_masked;
   end

   // ---- effective mode and permissions ----
   logic [MODE_W-1:0] eff_mode;
   dtc_mode_sel #(.MW(MODE_W)) u_mode (
      .priv_pc (req_priv_pc),
      .alt_req (req_alt),
      .alt_mode(alt_mode),
      .cur_mode(cur_mode),
      .eff_mode(eff_mode)
   );

   logic       perm_fault;
   dtc_fault_e perm_code;
   dtc_stat_t  perm_stat;
   dtc_perm_eval #(.MW(MODE_W)) u_perm (
      .is_store(req_store),
      .mode    (eff_mode),
      .rd_en   (tlb_rd_en),
      .wr_en   (tlb_wr_en),
      .fault_rd(tlb_fault_rd),
      .fault_wr(tlb_fault_wr),
      .fault   (perm_fault),
      .code    (perm_code),
      .stat    (perm_stat)
   );

   // ---- path selection ----
   logic [VA_W-1:0] pa_raw, tlb_pa;
   dtc_fault_e      path_f;
   dtc_stat_t       path_s;
   logic            ev_hit, ev_miss, ev_viol;
   assign tlb_pa = VA_W'({tlb_ppn, req_vaddr[PAGE_SHIFT-1:0]});

   always_comb begin
      pa_raw  = req_vaddr;
      path_f  = FLT_NONE;
      path_s  = '0;
      ev_hit  = 1'b0;
      ev_miss = 1'b0;
      ev_viol = 1'b0;
      if (misalign) begin
         path_f        = FLT_ALIGN;
         path_s[ST_WR] = req_store;
      end else if (req_phys) begin
         pa_raw = req_vaddr;
      end else if (!canon) begin
         path_f           = FLT_PAGE;
         path_s[ST_WR]    = req_store;
         path_s[ST_BADVA] = 1'b1;
         path_s[ST_ACV]   = 1'b1;
         ev_viol          = 1'b1;
      end else if (in_sp) begin
         if (cur_mode != '0) begin
            path_f         = FLT_ACV;
            path_s[ST_WR]  = req_store;
            path_s[ST_ACV] = 1'b1;
            ev_viol        = 1'b1;
         end else begin
            pa_raw = sp_pa;
            ev_hit = 1'b1;
         end
      end else if (!tlb_hit) begin
         path_f          = req_pt_fetch ? FLT_PT_MISS : FLT_MISS;
         path_s[ST_WR]   = req_store;
         path_s[ST_MISS] = 1'b1;
         ev_miss         = 1'b1;
      end else begin
         pa_raw = tlb_pa;
         if (perm_fault) begin
            path_f  = perm_code;
            path_s  = perm_stat;
            ev_viol = 1'b1;
         end else begin
            ev_hit = 1'b1;
         end
      end
   end

   // ---- final physical checks ----
   logic [PA_IMPL-1:0] pa_fin;
   logic               pa_mchk, pa_unc;
   dtc_pa_final #(
      .VA_W(VA_W), .PA_IMPL(PA_IMPL), .UNC_BIT(UNC_BIT), .UNC_CLR_LO(UNC_CLR_LO)
   ) u_fin (
      .pa_in   (pa_raw),
      .pa_out  (pa_fin),
      .mchk    (pa_mchk),
      .uncached(pa_unc)
   );

   dtc_fault_e fin_f;
   logic       ok;
   assign fin_f = (path_f == FLT_NONE && pa_mchk) ? FLT_MCHK : path_f;
   assign ok    = (fin_f == FLT_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_paddr    <= '0;
         rsp_fault    <= '0;
         rsp_status   <= '0;
         rsp_uncached <= 1'b0;
         rd_hit       <= 1'b0;
         rd_miss      <= 1'b0;
         rd_viol      <= 1'b0;
         wr_hit       <= 1'b0;
         wr_miss      <= 1'b0;
         wr_viol      <= 1'b0;
      end else begin
         rsp_valid    <= req_valid;
         rsp_paddr    <= (req_valid && ok) ? pa_fin : '0;
         rsp_fault    <= req_valid ? fin_f : FLT_NONE;
         rsp_status   <= req_valid ? path_s : '0;
         rsp_uncached <= req_valid && ok && pa_unc;
         rd_hit       <= req_valid && !req_store && ev_hit;
         rd_miss      <= req_valid && !req_store && ev_miss;
         rd_viol      <= req_valid && !req_store && ev_viol;
         wr_hit       <= req_valid && req_store && ev_hit;
         wr_miss      <= req_valid && req_store && ev_miss;
         wr_viol      <= req_valid && req_store && ev_viol;
      end
   end
endmodule

// File: rtl/dtc_xlate_chk.sv
module dtc_xlate_chk #(
   parameter int PA_IMPL    = 44,
   parameter int UNC_BIT    = 43,
   parameter int UNC_CLR_LO = 35
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               rsp_valid,
   input logic [PA_IMPL-1:0] rsp_paddr,
   input logic [2:0]         rsp_fault,
   input logic [5:0]         rsp_status,
   input logic               rsp_uncached,
   input logic               rd_hit,
   input logic               rd_miss,
   input logic               rd_viol,
   input logic               wr_hit,
   input logic               wr_miss,
   input logic               wr_viol
);
   logic [5:0] strobes;
   assign strobes = {rd_hit, rd_miss, rd_viol, wr_hit, wr_miss, wr_viol};

   // R12
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(strobes));

   // R12
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (strobes == 6'd0 && rsp_fault == 3'd0 && rsp_paddr == '0));

   // R1
   align_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fault == 3'd1) |-> (strobes == 6'd0 && rsp_status[5:1] == 5'd0));

   // R6
   miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fault == 3'd4 || rsp_fault == 3'd5) |-> (rsp_status[3] && (rd_miss || wr_miss)));

   // R7
   store_viol_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_viol |-> rsp_status[0]);

   // R12
   fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fault != 3'd0) |-> (rsp_paddr == '0 && !rsp_uncached));

   // R11
   uncached_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_uncached |-> (rsp_paddr[UNC_BIT] && rsp_paddr[UNC_BIT-1:UNC_CLR_LO] == '0));
endmodule

bind dtc_xlate dtc_xlate_chk #(
   .PA_IMPL(PA_IMPL), .UNC_BIT(UNC_BIT), .UNC_CLR_LO(UNC_CLR_LO)
) chk_i (.*);

// File: tb/dtc_xlate_tb_top.sv
`timescale 1ns/1ps
module dtc_xlate_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_vaddr = '0;
   logic [1:0]  req_size = '0;
   logic        req_store = 1'b0, req_priv_pc = 1'b0, req_alt = 1'b0;
   logic        req_phys = 1'b0, req_pt_fetch = 1'b0;
   logic [1:0]  alt_mode = '0, cur_mode = '0;
   logic        tlb_hit = 1'b0;
   logic [31:0] tlb_ppn = '0;
   logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
   logic        tlb_fault_rd = 1'b0, tlb_fault_wr = 1'b0;

   logic        rsp_valid, rsp_uncached;
   logic [43:0] rsp_paddr;
   logic [2:0]  rsp_fault;
   logic [5:0]  rsp_status;
   logic        rd_hit, rd_miss, rd_viol, wr_hit, wr_miss, wr_viol;

   always #2.5 clk = ~clk;

   dtc_xlate dut_i (.*);

   typedef struct packed {
      logic        v;
      logic [63:0] va;
      logic [1:0]  sz;
      logic        st, priv, altf;
      logic [1:0]  altm, curm;
      logic        phys, ptf, hit;
      logic [31:0] ppn;
      logic [3:0]  re, we;
      logic        fr, fw;
   } req_t;

   typedef struct packed {
      logic        v;
      logic [43:0] pa;
      logic [2:0]  f;
      logic [5:0]  s;
      logic        unc;
      logic [5:0]  stb; // rh rm rv wh wm wv
   } exp_t;

   int    n_chk = 0, n_fail = 0;
   bit    done = 1'b0;
   exp_t  exp_q = '0;
   string exp_tag = "R12";

   function automatic exp_t model(input req_t r, output string tag);
      exp_t        e;
      logic [63:0] pa;
      logic [1:0]  md;
      logic        h, m, vi;
      e = '0; tag = "R12"; h = 0; m = 0; vi = 0; pa = r.va;
      if (!r.v) return e;
      e.v = 1'b1;
      md = r.priv ? (r.altf ? r.altm : 2'd0) : r.curm;
      if ((r.va & ((64'd1 << r.sz) - 64'd1)) != 0) begin
         tag = "R1"; e.f = 3'd1; e.s[0] = r.st;
      end else if (r.phys) begin
         tag = "R3";
      end else if (!(r.va[63:47] == '0 || r.va[63:47] == '1)) begin
         tag = "R4"; e.f = 3'd2; e.s = {3'b000, 1'b1, 1'b1, r.st}; vi = 1;
      end else if (r.va[47:41] == 7'h7E) begin
         tag = "R5";
         if (r.curm != 2'd0) begin
            e.f = 3'd3; e.s = {3'b000, 1'b1, 1'b0, r.st}; vi = 1;
         end else begin
            pa = r.va & 64'hFFF_FFFF_FFFF;
            if (pa[40]) pa = pa | 64'hF00_0000_0000;
            else        pa = pa & 64'h0FF_FFFF_FFFF;
            h = 1;
         end
      end else if (!r.hit) begin
         tag = "R6"; e.f = r.ptf ? 3'd4 : 3'd5; e.s = {2'b00, 1'b1, 2'b00, r.st}; m = 1;
      end else begin
         pa = ({32'd0, r.ppn} << 13) + {51'd0, r.va[12:0]};
         tag = r.priv ? "R2" : "R9";
         if (r.st) begin
            if (!r.we[md])    begin tag = "R7"; e.f = 3'd2; e.s = {r.fw, 3'b001, 1'b0, 1'b1}; vi = 1; end
            else if (r.fw)    begin tag = "R7"; e.f = 3'd2; e.s = 6'b100001; vi = 1; end
            else h = 1;
         end else begin
            if (!r.re[md])    begin tag = "R8"; e.f = 3'd3; e.s = {1'b0, r.fr, 4'b0100}; vi = 1; end
            else if (r.fr)    begin tag = "R8"; e.f = 3'd2; e.s = 6'b010000; vi = 1; end
            else h = 1;
         end
      end
      if (e.f == 3'd0) begin
         if (pa[63:44] != 0) begin
            tag = "R10"; e.f = 3'd6; pa = 0;
         end else if (pa[43]) begin
            tag = "R11"; e.unc = 1; pa[42:35] = 8'd0;
         end
         e.pa = pa[43:0];
      end
      e.stb = r.st ? {3'b000, h, m, vi} : {h, m, vi, 3'b000};
      return e;
   endfunction

   task automatic check_now();
      exp_t act;
      act = '{v: rsp_valid, pa: rsp_paddr, f: rsp_fault, s: rsp_status, unc: rsp_uncached,
              stb: {rd_hit, rd_miss, rd_viol, wr_hit, wr_miss, wr_viol}};
      n_chk++;
      if (act !== exp_q) begin
         n_fail++;
         $display("FAIL %s: actual v=%0b pa=%h f=%0d s=%b unc=%0b stb=%b expected v=%0b pa=%h f=%0d s=%b unc=%0b stb=%b",
                  exp_tag, act.v, act.pa, act.f, act.s, act.unc, act.stb,
                  exp_q.v, exp_q.pa, exp_q.f, exp_q.s, exp_q.unc, exp_q.stb);
      end
   endtask

   task automatic send(input req_t r);
      string t;
      @(negedge clk);
      check_now();
      req_valid = r.v;     req_vaddr = r.va;   req_size = r.sz;   req_store = r.st;
      req_priv_pc = r.priv; req_alt = r.altf;  alt_mode = r.altm; cur_mode = r.curm;
      req_phys = r.phys;   req_pt_fetch = r.ptf; tlb_hit = r.hit;  tlb_ppn = r.ppn;
      tlb_rd_en = r.re;    tlb_wr_en = r.we;   tlb_fault_rd = r.fr; tlb_fault_wr = r.fw;
      exp_q = model(r, t);
      exp_tag = t;
   endtask

   function automatic req_t base(input logic [63:0] va, input logic st);
      req_t r;
      r = '0; r.v = 1; r.va = va; r.st = st; r.hit = 1; r.ppn = 32'h123;
      r.re = 4'hF; r.we = 4'hF;
      return r;
   endfunction

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      req_t r;
      repeat (3) @(negedge clk);
      check_now();                                      // R12 reset state
      rst_n = 1'b1;

      // R1 misaligned load, and misaligned store beating physical bypass
      r = base(64'h1002, 0); r.sz = 2; send(r);
      r = base(64'h0FFF_0000_0004, 1); r.sz = 3; r.phys = 1; send(r);
      // R3 physical bypass, and R10 via bypass
      r = base(64'h0000_0123_4560, 0); r.phys = 1; send(r);
      r = base(64'h0004_0000_0000_0000, 1); r.phys = 1; send(r);
      // R4 non-canonical load and store
      r = base(64'h0001_0000_0000_0000, 0); send(r);
      r = base(64'hFFFE_8000_0000_0000, 1); send(r);
      // R5 superpage, both extension cases (second one also R11)
      r = base(64'hFFFF_FC00_0001_2340, 0); send(r);
      r = base(64'hFFFF_FD00_0001_2340, 1); send(r);
      r = base(64'hFFFF_FC00_0001_2340, 1); r.curm = 3; send(r);
      // R5 uses current mode even when privileged code selects an alt mode
      r = base(64'hFFFF_FC00_0000_0000, 0); r.priv = 1; r.altf = 1; r.altm = 3; send(r);
      r = base(64'hFFFF_FC00_0000_0000, 0); r.priv = 1; r.curm = 2; send(r);
      // R6 misses
      r = base(64'h4000, 0); r.hit = 0; send(r);
      r = base(64'h4000, 1); r.hit = 0; r.ptf = 1; send(r);
      // R9 hits; R10 and R11 through the lookup
      r = base(64'h6ABC, 0); r.ppn = 32'h0ABC_DEF1; send(r);
      r = base(64'h6ABC, 1); r.ppn = 32'h8000_0000; send(r);
      r = base(64'h6ABC, 0); r.ppn = 32'h4FF0_0001; send(r);
      // R7 store permission and fault-on-write
      r = base(64'h2000, 1); r.we = 4'hE; r.fw = 1; send(r);
      r = base(64'h2000, 1); r.we = 4'hE; send(r);
      r = base(64'h2000, 1); r.fw = 1; send(r);
      // R8 load permission and fault-on-read
      r = base(64'h2000, 0); r.re = 4'hE; r.fr = 1; send(r);
      r = base(64'h2000, 0); r.re = 4'hE; send(r);
      r = base(64'h2000, 0); r.fr = 1; send(r);
      // R2 effective mode
      r = base(64'h2000, 0); r.priv = 1; r.curm = 3; r.re = 4'h1; send(r);
      r = base(64'h2000, 0); r.priv = 1; r.altf = 1; r.altm = 2; r.re = 4'h4; send(r);
      r = base(64'h2000, 1); r.priv = 1; r.altf = 1; r.altm = 2; r.we = 4'hB; send(r);
      r = base(64'h2000, 0); r.curm = 1; r.re = 4'h1; send(r);
      // R12 idle cycles between requests
      r = '0; send(r); send(r);

      for (int i = 0; i < 3000; i++) begin
         r = '0;
         r.v = ($urandom % 5) != 0;
         case ($urandom % 5)
            0: r.va = 64'hFFFF_FC00_0000_0000 | {24'd0, 40'($urandom)} | (64'($urandom % 2) << 40);
            1: r.va = {$urandom, $urandom};
            default: r.va = {32'd0, $urandom};
         endcase
         r.sz = 2'($urandom); if (($urandom % 3) != 0) r.va = r.va & ~64'h7;
         r.st = 1'($urandom); r.priv = 1'($urandom); r.altf = 1'($urandom);
         r.altm = 2'($urandom); r.curm = 2'($urandom); r.phys = (($urandom % 8) == 0);
         r.ptf = 1'($urandom); r.hit = ($urandom % 4) != 0;
         r.ppn = ($urandom % 3 == 0) ? $urandom : ($urandom & 32'h07FF_FFFF);
         r.re = 4'($urandom); r.we = 4'($urandom);
         r.fr = ($urandom % 4) == 0; r.fw = ($urandom % 4) == 0;
         send(r);
      end
      r = '0; send(r);
      @(negedge clk); check_now();

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule